// File: doc/BRIEF.md
# Banked Active-Priority Register with Running-Priority Readout

This block holds the active-priority state of an interrupt controller CPU interface, with one 32-bit copy for each interrupt domain. Each bit of a copy marks one of the 32 priority levels as active. Software reaches the copy that belongs to the current logical domain through a single-cycle access port with a 64-bit data path. A separate view reports the running priority of the current physical domain. The running priority is the index of the lowest set bit in that domain's copy, or an idle code when the copy is empty.

The access port carries a strobe `acc_en`, a direction bit `acc_wr` and a register select `acc_sel`. `acc_sel` = 0 addresses the active-priority copy and `acc_sel` = 1 addresses the running-priority register, which can only be read. A read strobe loads `rdata` at the next clock edge, and `rdata` keeps that value until the next read strobe. The running priority of the physical domain is also driven continuously on `run_prio`.

The block has no state machine. Its one named selector is the register-select enumeration, with the codes APR (0) and RPR (1). The read multiplexer switches on this selector. There are no states and no transitions to list.

Top module: `actprio_bank`

## Requirements
- R1: A synchronous reset (`rst` = 1 at a clock edge) clears the copies of all four domains to zero.
- R2: A write (`acc_en`=1, `acc_wr`=1, `acc_sel`=0) stores `wdata[31:0]` in the copy selected by `log_dom` and discards `wdata[63:32]`.
- R3: A write changes only the copy of the domain named by `log_dom`. The other three copies keep their values.
- R4: A read (`acc_en`=1, `acc_wr`=0, `acc_sel`=0) loads `rdata` at the next edge with the logical domain's copy in bits [31:0] and zero in bits [63:32].
- R5: `run_prio` equals the bit index (0 to 31) of the least-significant set bit of the copy selected by `phys_dom`.
- R6: When the copy selected by `phys_dom` is zero, `run_prio` is 8'hFF.
- R7: `run_prio` depends on `phys_dom` only. Changing `log_dom` does not affect it.
- R8: A write with `acc_sel`=1 has no effect on any copy. A read with `acc_sel`=1 loads `rdata` with `run_prio` zero-extended to 64 bits.
- R9: A value written to a domain's copy is reflected on `run_prio` in the cycle right after the write's clock edge.
- R10: `rdata` keeps its value in every cycle that has no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| log_dom | input | 2 | Logical domain for register access |
| phys_dom | input | 2 | Physical domain for the running-priority view |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = active-priority copy, 1 = running-priority register |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, loaded one edge after a read strobe |
| run_prio | output | 8 | Running priority of the physical domain (8'hFF when idle) |

## Verification
The assertions assume that the domain selectors and the access controls are steady around each clock edge, and that reset is asserted at an edge before any check relies on cleared state. They also assume that a strobe is either a read or a write, never both, which holds because the direction comes from the single bit `acc_wr`. The bench changes every input at the falling edge and holds it for a full cycle. It asserts reset before any access and again in the middle of the run.

// File: rtl/actprio_pkg.sv
package actprio_pkg;
    localparam int NUM_DOM   = 4;
    localparam int DOM_W     = $clog2(NUM_DOM);
    localparam int DATA_W    = 64;
    localparam int PRIO_BITS = 5;
    localparam int APR_W     = 1 << PRIO_BITS;
    localparam int RP_W      = 8;
    localparam logic [RP_W-1:0] RP_IDLE = '1;

    typedef enum logic {
        SEL_APR = 1'b0,
        SEL_RPR = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/actprio_regfile.sv
module actprio_regfile
    import actprio_pkg::*;
#(
    parameter int N  = NUM_DOM,
    parameter int W  = APR_W,
    parameter int DW = DOM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_dom,
    input  logic [W-1:0]  wr_val,
    input  logic [DW-1:0] rd_dom_a,
    input  logic [DW-1:0] rd_dom_b,
    output logic [W-1:0]  rd_val_a,
    output logic [W-1:0]  rd_val_b
);
    logic [N-1:0][W-1:0] bank;

    for (genvar d = 0; d < N; d++) begin : g_dom
        logic [W-1:0] q;
        logic         hit;

        assign hit = wr_en && (wr_dom == DW'(d));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                q <= wr_val;
            end
        end

        assign bank[d] = q;

        // R1: reset empties this copy
        p_reset_clear_r1: assert property (@(posedge clk)
            rst |=> (bank[d] == '0));
        // R2: a write aimed here lands here
        p_write_store_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_dom == DW'(d)) |=> (bank[d] == $past(wr_val)));
        // R3: other domains' writes leave this copy alone
        p_other_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_dom == DW'(d)) |=> $stable(bank[d]));
    end

    assign rd_val_a = bank[rd_dom_a];
    assign rd_val_b = bank[rd_dom_b];
endmodule

// File: rtl/actprio_lsb.sv
module actprio_lsb
    import actprio_pkg::*;
#(
    parameter int              W    = APR_W,
    parameter int              OW   = RP_W,
    parameter logic [OW-1:0]   IDLE = RP_IDLE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  vec,
    output logic [OW-1:0] prio
);
    localparam int IW = $clog2(W);

    always_comb begin
        prio = IDLE;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                prio = OW'(i);
            end
        end
    end

    // R6: an empty vector gives the idle code
    p_idle_code_r6: assert property (@(posedge clk) disable iff (rst)
        (vec == '0) |-> (prio == IDLE));
    // R5: the reported bit is set and no lower bit is set
    p_lowest_set_r5: assert property (@(posedge clk) disable iff (rst)
        (vec != '0) |-> ((prio < OW'(W)) && vec[prio[IW-1:0]] &&
            ((vec & ((W'(1) << prio[IW-1:0]) - W'(1))) == '0)));
endmodule

// File: rtl/actprio_bank.sv
module actprio_bank
    import actprio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DOM_W-1:0]  log_dom,
    input  logic [DOM_W-1:0]  phys_dom,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [RP_W-1:0]   run_prio
);
    reg_sel_e          sel;
    logic              wr_go;
    logic              rd_go;
    logic [APR_W-1:0]  apr_log;
    logic [APR_W-1:0]  apr_phys;
    logic [DATA_W-1:0] rd_next;

    assign sel   = reg_sel_e'(acc_sel);
    assign wr_go = acc_en && acc_wr && (sel == SEL_APR);
    assign rd_go = acc_en && !acc_wr;

    actprio_regfile #(
        .N (NUM_DOM),
        .W (APR_W),
        .DW(DOM_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go),
        .wr_dom  (log_dom),
        .wr_val  (wdata[APR_W-1:0]),
        .rd_dom_a(log_dom),
        .rd_dom_b(phys_dom),
        .rd_val_a(apr_log),
        .rd_val_b(apr_phys)
    );

    actprio_lsb #(
        .W   (APR_W),
        .OW  (RP_W),
        .IDLE(RP_IDLE)
    ) u_lsb (
        .clk (clk),
        .rst (rst),
        .vec (apr_phys),
        .prio(run_prio)
    );

    always_comb begin
        unique case (sel)
            SEL_APR: rd_next = {{(DATA_W - APR_W){1'b0}}, apr_log};
            SEL_RPR: rd_next = {{(DATA_W - RP_W){1'b0}}, run_prio};
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_go) begin
            rdata <= rd_next;
        end
    end

    // R10: no read strobe, no change on rdata
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && !acc_wr) |=> $stable(rdata));
    // R4: active-priority reads never carry upper bits
    p_apr_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && !acc_sel) |=> (rdata[DATA_W-1:APR_W] == '0));
    // R8: running-priority reads return the readout, zero-extended
    p_rpr_read_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && acc_sel) |=>
            ((rdata[DATA_W-1:RP_W] == '0) && (rdata[RP_W-1:0] == $past(run_prio))));
endmodule

// File: tb/actprio_bank_tb.sv
module actprio_bank_tb;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  log_dom;
    logic [1:0]  phys_dom;
    logic        acc_en;
    logic        acc_wr;
    logic        acc_sel;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic [7:0]  run_prio;

    int errors = 0;
    int checks = 0;
    logic [31:0] mdl [4];

    always #(TCK / 2) clk = ~clk;

    actprio_bank u_dut (
        .clk     (clk),
        .rst     (rst),
        .log_dom (log_dom),
        .phys_dom(phys_dom),
        .acc_en  (acc_en),
        .acc_wr  (acc_wr),
        .acc_sel (acc_sel),
        .wdata   (wdata),
        .rdata   (rdata),
        .run_prio(run_prio)
    );

    function automatic logic [7:0] exp_rp(input logic [31:0] v);
        if (v == 32'd0) return 8'hFF;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) return 8'(i);
        end
        return 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int d = 0; d < 4; d++) mdl[d] = 32'd0;
    endtask

    task automatic do_wr(input logic sel, input logic [1:0] ld, input logic [63:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_sel = sel; log_dom = ld; wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; wdata = 64'hA5A5_A5A5_A5A5_A5A5;
        if (!sel) mdl[ld] = d[31:0];
    endtask

    task automatic do_rd(input logic sel, input logic [1:0] ld, output logic [63:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_sel = sel; log_dom = ld;
        @(negedge clk);
        acc_en = 1'b0;
        v = rdata;
    endtask

    task automatic check_all_apr(input string tag);
        logic [63:0] v;
        for (int d = 0; d < 4; d++) begin
            do_rd(1'b0, 2'(d), v);
            chk(v == {32'd0, mdl[d]}, tag, v, {32'd0, mdl[d]});
        end
    endtask

    task automatic check_all_rp(input string tag);
        for (int p = 0; p < 4; p++) begin
            for (int l = 0; l < 4; l++) begin
                @(negedge clk);
                phys_dom = 2'(p); log_dom = 2'(l);
                #1;
                chk(run_prio == exp_rp(mdl[p]), tag, 64'(run_prio), 64'(exp_rp(mdl[p])));
            end
        end
    endtask

    initial begin
        #(TCK * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [63:0] held;
        rst = 1'b1; log_dom = '0; phys_dom = '0; acc_en = 1'b0; acc_wr = 1'b0;
        acc_sel = 1'b0; wdata = '0;
        do_reset();

        // R1, R6: all copies empty, idle readout everywhere
        check_all_apr("R1 reset apr");
        check_all_rp("R6 idle after reset");

        // R2, R3: garbage upper half discarded, only target copy changes
        for (int d = 0; d < 4; d++) begin
            do_wr(1'b0, 2'(d), {32'hDEAD_BEEF ^ 32'(d), 32'h0001_0000 << d});
            check_all_apr("R2 R3 store and isolate");
        end
        // R4, R5, R7: every phys/log pairing
        check_all_rp("R5 R7 lsb by phys domain");

        // R5, R9: walking lowest bit with junk above, read in the next cycle
        for (int b = 0; b < 32; b++) begin
            logic [1:0] dm;
            dm = 2'(b % 4);
            do_wr(1'b0, dm, {32'hFFFF_FFFF, 32'hFFFF_FFFF << b});
            phys_dom = dm; log_dom = dm + 2'd1;
            #1;
            chk(run_prio == 8'(b), "R9 R5 visible next cycle", 64'(run_prio), 64'(b));
        end
        check_all_apr("R4 after sweep");

        // R6: clearing a copy returns it to idle
        do_wr(1'b0, 2'd2, 64'hFFFF_FFFF_0000_0000);
        phys_dom = 2'd2; #1;
        chk(run_prio == 8'hFF, "R6 cleared copy idle", 64'(run_prio), 64'hFF);

        // R8: writes to the running-priority register are dropped
        for (int d = 0; d < 4; d++) do_wr(1'b1, 2'(d), 64'h0000_0000_0000_0001);
        check_all_apr("R8 rpr write ignored");
        check_all_rp("R8 rpr write ignored rp");

        // R8: reading running priority returns zero-extended readout
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            phys_dom = 2'(p);
            do_rd(1'b1, 2'(3 - p), v);
            chk(v == {56'd0, exp_rp(mdl[p])}, "R8 rpr read", v, {56'd0, exp_rp(mdl[p])});
        end

        // R10: rdata holds while no read strobe, selectors moving
        do_rd(1'b0, 2'd1, held);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            log_dom = 2'(k); phys_dom = 2'(k + 1); acc_sel = k[0];
            chk(rdata == held, "R10 rdata hold", rdata, held);
        end
        do_wr(1'b0, 2'd1, 64'h0000_0000_0000_0080);
        chk(rdata == held, "R10 rdata hold over write", rdata, held);

        // R1: reset mid-run clears again
        do_reset();
        check_all_apr("R1 second reset");
        check_all_rp("R1 R6 second reset rp");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule